// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block recovers characters from an asynchronous serial input line. A baud-rate enable pulse at sixteen times the bit rate drives it. It watches the line for a falling edge while reception is enabled, confirms the start bit at its centre, and then samples each following element at the centre of its bit period. The character length, the parity mode, the stop-bit count, the bit order, the data-level inversion and the line-level inversion are all set by static configuration inputs, which must match the sending side.

A finished character is moved into a single receive buffer. The move raises a one-cycle interrupt and sets a full indication, which a read strobe clears. Framing, parity and overrun conditions are reported as flags, together with their logical OR. Overrun is decided partway through the following frame. An optional request-to-send output tells the far end whether the receiver can accept data.

Top module: `uart_rx_core`

## Requirements
- R1: A frame begins only when `rx_en` is 1 and the conditioned line is low on a baud tick while idle. Driving `rx_en` to 0 abandons any frame in progress, blocks new ones, and clears all three error flags.
- R2: The `cfg_len` input selects the character length: 0 gives 7 bits, 1 gives 8 bits, and 2 or 3 give 9 bits. Buffer bits above the character length read as 0.
- R3: When `cfg_par_en`=1 a parity bit follows the character. `cfg_par_odd`=0 selects even parity, where the data ones and the parity bit together hold an even count. `cfg_par_odd`=1 selects odd parity. A mismatch sets `err_parity` when the character is stored.
- R4: `cfg_two_stop` chooses one stop bit (0) or two stop bits (1). If any expected stop element is sampled low, `err_framing` is set.
- R5: Storing a character sets `rx_full` and pulses `rx_irq` high for exactly one clock, in the same cycle that the new data appears on `rx_data`.
- R6: An overrun is pending when the buffer is full, and not being read in that same cycle, at the sample of the element just before the last stop element of a frame.
- R7: When a frame ends with an overrun pending, `err_overrun` is set and `rx_irq` stays low. `rx_data` keeps its old content and `rx_full` stays 1.
- R8: `err_sum` is 1 exactly when at least one of `err_overrun`, `err_framing` and `err_parity` is 1. The flags are rewritten when each frame ends.
- R9: With `cfg_msb_first`=0 the first received data bit lands in bit 0. With `cfg_msb_first`=1 it lands in bit (length-1).
- R10: With `cfg_data_inv`=1 the data and parity bits are complemented before use. Start and stop bits are not complemented.
- R11: With `cfg_line_inv`=1 the `rxd` input is complemented before any other processing, including start detection.
- R12: Each element is sampled on the 8th tick of its 16-tick period. A start bit that reads high at that point is discarded, and the receiver returns to idle.
- R13: With `cfg_rts_en`=1, `rts_n` is 0 when `rx_en`=1 and `rx_full`=0, and 1 otherwise. With `cfg_rts_en`=0, `rts_n` is 0.
- R14: `rd_strobe` clears `rx_full`. If a character is stored in the same cycle, the store wins and `rx_full` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle enable at 16x the bit rate |
| rx_en | input | 1 | Reception enable |
| rxd | input | 1 | Serial input line |
| cfg_len | input | 2 | Character length select |
| cfg_par_en | input | 1 | Parity present |
| cfg_par_odd | input | 1 | Odd parity when 1 |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_msb_first | input | 1 | MSB-first bit order |
| cfg_data_inv | input | 1 | Complement data and parity bits |
| cfg_line_inv | input | 1 | Complement the whole line |
| cfg_rts_en | input | 1 | Enable request-to-send output |
| rd_strobe | input | 1 | Buffer read strobe |
| rx_data | output | 9 | Receive buffer content |
| rx_full | output | 1 | Buffer holds an unread character |
| rx_irq | output | 1 | Character-stored pulse |
| err_overrun | output | 1 | Overrun flag |
| err_framing | output | 1 | Framing error flag |
| err_parity | output | 1 | Parity error flag |
| err_sum | output | 1 | OR of the error flags |
| rts_n | output | 1 | Request to send, active low |

## Verification
Two pairs of events can land on the same clock. The first is the buffer read strobe against the overrun decision taken at the element before the last stop. The second is the read strobe against the store of a completed character. The bench drives every baud tick itself, so it knows which tick carries each sample and can raise `rd_strobe` on exactly that tick. A read that coincides with the overrun decision must leave the frame stored normally, with a fresh interrupt and no overrun. A read that coincides with a store must leave `rx_full` at 1.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_FRAME} rx_state_e;

  // character length in bits from the length code
  function automatic logic [3:0] char_bits(input logic [1:0] len_code);
    case (len_code)
      2'd0:    return 4'd7;
      2'd1:    return 4'd8;
      default: return 4'd9;
    endcase
  endfunction

  // elements sampled after the start bit: data + parity + stops
  function automatic logic [3:0] frame_elems(input logic [1:0] len_code,
                                             input logic par_en,
                                             input logic two_stop);
    return char_bits(len_code) + {3'd0, par_en} + 4'd1 + {3'd0, two_stop};
  endfunction

  // buffer position for the data element received in order idx
  function automatic logic [3:0] bit_slot(input logic [3:0] idx,
                                          input logic [1:0] len_code,
                                          input logic msb_first);
    return msb_first ? (char_bits(len_code) - 4'd1 - idx) : idx;
  endfunction

  // one when data ones plus parity bit break the selected rule
  function automatic logic parity_bad(input logic [8:0] data,
                                      input logic par_bit,
                                      input logic odd);
    return ((^data) ^ par_bit) != odd;
  endfunction

endpackage

// File: rtl/rx_line_cond.sv
module rx_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  input  logic line_inv,
  output logic rx_s
);
  logic [SYNC_STAGES-1:0] stage_q;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      stage_q[g] <= 1'b1;
        else if (g == 0) stage_q[g] <= rxd ^ line_inv;
        else             stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign rx_s = stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx_en,
  input  logic          rx_s,
  input  logic [1:0]    len_code,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          two_stop,
  input  logic          msb_first,
  input  logic          data_inv,
  output logic          ovr_chk_evt,
  output logic          done_evt,
  output logic [DW-1:0] frm_data,
  output logic          frm_fe,
  output logic          frm_pe
);
  localparam int PHW = $clog2(OSR);
  localparam logic [PHW-1:0] MID  = PHW'(OSR/2 - 1);
  localparam logic [PHW-1:0] LAST = PHW'(OSR - 1);

  rx_state_e      state;
  logic [PHW-1:0] ph;
  logic [3:0]     idx;
  logic [DW-1:0]  shreg;
  logic           par_q, fe_q;
  logic [3:0]     nbits, last_idx;
  logic           samp_evt;

  assign nbits    = char_bits(len_code);
  assign last_idx = frame_elems(len_code, par_en, two_stop) - 4'd1;
  assign samp_evt = rx_en && tick && (state == RX_FRAME) && (ph == LAST);
  assign done_evt    = samp_evt && (idx == last_idx);
  assign ovr_chk_evt = samp_evt && (idx == last_idx - 4'd1);
  assign frm_data = shreg;
  assign frm_fe   = fe_q | ~rx_s;
  assign frm_pe   = par_en & parity_bad(shreg, par_q, par_odd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      ph    <= '0;
      idx   <= '0;
      shreg <= '0;
      par_q <= 1'b0;
      fe_q  <= 1'b0;
    end else if (!rx_en) begin
      state <= RX_IDLE;
    end else if (tick) begin
      case (state)
        RX_IDLE: if (!rx_s) begin
          state <= RX_START;
          ph    <= '0;
        end
        RX_START: if (ph == MID) begin
          state <= rx_s ? RX_IDLE : RX_FRAME;
          ph    <= '0;
          idx   <= '0;
          shreg <= '0;
          par_q <= 1'b0;
          fe_q  <= 1'b0;
        end else begin
          ph <= ph + 1'b1;
        end
        RX_FRAME: if (ph == LAST) begin
          ph  <= '0;
          idx <= idx + 4'd1;
          if (idx < nbits)
            shreg[bit_slot(idx, len_code, msb_first)] <= rx_s ^ data_inv;
          else if (par_en && idx == nbits)
            par_q <= rx_s ^ data_inv;
          else if (!rx_s)
            fe_q <= 1'b1;
          if (idx == last_idx) state <= RX_IDLE;
        end else begin
          ph <= ph + 1'b1;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // a start bit seen high at its centre must not open a frame
  assert_noise_reject_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_START && rx_en && tick && ph == MID && rx_s) |=> state == RX_IDLE);

  // leaving idle needs a low line sample
  assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_IDLE && rx_s) |=> state != RX_START);

  // completion and the overrun check never share a sample
  assert_chk_before_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_evt && ovr_chk_evt));
endmodule

// File: rtl/rx_buffer.sv
module rx_buffer #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          rd_strobe,
  input  logic          ovr_chk_evt,
  input  logic          done_evt,
  input  logic [DW-1:0] frm_data,
  input  logic          frm_fe,
  input  logic          frm_pe,
  output logic [DW-1:0] rx_data,
  output logic          rx_full,
  output logic          rx_irq,
  output logic          err_overrun,
  output logic          err_framing,
  output logic          err_parity
);
  logic ovr_pend;
  logic load_evt;

  assign load_evt = done_evt && !ovr_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_full     <= 1'b0;
      rx_irq      <= 1'b0;
      ovr_pend    <= 1'b0;
      err_overrun <= 1'b0;
      err_framing <= 1'b0;
      err_parity  <= 1'b0;
    end else begin
      rx_irq <= load_evt;
      if (load_evt)       rx_full <= 1'b1;
      else if (rd_strobe) rx_full <= 1'b0;
      if (load_evt) rx_data <= frm_data;
      if (!rx_en) begin
        ovr_pend    <= 1'b0;
        err_overrun <= 1'b0;
        err_framing <= 1'b0;
        err_parity  <= 1'b0;
      end else if (done_evt) begin
        ovr_pend    <= 1'b0;
        err_overrun <= ovr_pend;
        err_framing <= frm_fe;
        err_parity  <= frm_pe;
      end else if (ovr_chk_evt) begin
        ovr_pend <= rx_full && !rd_strobe;
      end
    end
  end

  assert_irq_with_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_full);

  assert_ovr_no_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && ovr_pend) |=> (!rx_irq && rx_full && $stable(rx_data)));

  assert_rd_clears_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !done_evt) |=> !rx_full);

  assert_ovr_needs_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> rx_full);
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DW          = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          rx_en,
  input  logic          rxd,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          cfg_two_stop,
  input  logic          cfg_msb_first,
  input  logic          cfg_data_inv,
  input  logic          cfg_line_inv,
  input  logic          cfg_rts_en,
  input  logic          rd_strobe,
  output logic [DW-1:0] rx_data,
  output logic          rx_full,
  output logic          rx_irq,
  output logic          err_overrun,
  output logic          err_framing,
  output logic          err_parity,
  output logic          err_sum,
  output logic          rts_n
);
  logic          rx_s;
  logic          ovr_chk_evt, done_evt, frm_fe, frm_pe;
  logic [DW-1:0] frm_data;

  rx_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .line_inv(cfg_line_inv), .rx_s(rx_s));

  rx_frame_fsm #(.OSR(OSR), .DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rx_en(rx_en), .rx_s(rx_s),
    .len_code(cfg_len), .par_en(cfg_par_en), .par_odd(cfg_par_odd),
    .two_stop(cfg_two_stop), .msb_first(cfg_msb_first), .data_inv(cfg_data_inv),
    .ovr_chk_evt(ovr_chk_evt), .done_evt(done_evt), .frm_data(frm_data),
    .frm_fe(frm_fe), .frm_pe(frm_pe));

  rx_buffer #(.DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_strobe(rd_strobe),
    .ovr_chk_evt(ovr_chk_evt), .done_evt(done_evt), .frm_data(frm_data),
    .frm_fe(frm_fe), .frm_pe(frm_pe), .rx_data(rx_data), .rx_full(rx_full),
    .rx_irq(rx_irq), .err_overrun(err_overrun), .err_framing(err_framing),
    .err_parity(err_parity));

  assign err_sum = err_overrun | err_framing | err_parity;
  assign rts_n   = cfg_rts_en ? ~(rx_en & ~rx_full) : 1'b0;

  // after a store the buffer is full, so a ready indication must be withdrawn
  assert_rts_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rts_en && rx_irq) |-> rts_n);

  assert_sum_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_parity) |-> err_sum);
endmodule

// File: tb/tb_uart_rx_core.sv
module tb_uart_rx_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud_tick = 1'b0, rx_en = 1'b0, rxd = 1'b1, rd_strobe = 1'b0;
  logic [1:0] cfg_len = 2'd1;
  logic cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0, cfg_msb_first = 0;
  logic cfg_data_inv = 0, cfg_line_inv = 0, cfg_rts_en = 0;
  logic [8:0] rx_data;
  logic rx_full, rx_irq, err_overrun, err_framing, err_parity, err_sum, rts_n;

  int checks = 0, fails = 0, irq_cnt = 0;
  logic lv [0:12];
  int   nlv;

  always #4 clk = ~clk;

  uart_rx_core dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_en(rx_en), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_two_stop(cfg_two_stop), .cfg_msb_first(cfg_msb_first),
    .cfg_data_inv(cfg_data_inv), .cfg_line_inv(cfg_line_inv),
    .cfg_rts_en(cfg_rts_en), .rd_strobe(rd_strobe), .rx_data(rx_data),
    .rx_full(rx_full), .rx_irq(rx_irq), .err_overrun(err_overrun),
    .err_framing(err_framing), .err_parity(err_parity), .err_sum(err_sum),
    .rts_n(rts_n));

  always @(negedge clk) if (rst_n && rx_irq) irq_cnt++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nbits_of(input logic [1:0] c);
    return (c == 2'd0) ? 7 : (c == 2'd1) ? 8 : 9;
  endfunction

  // one baud tick, optionally with a read strobe in the same clock
  task automatic do_tick(input bit rd);
    repeat (2) @(negedge clk);
    baud_tick = 1'b1;
    rd_strobe = rd;
    @(negedge clk);
    baud_tick = 1'b0;
    rd_strobe = 1'b0;
  endtask

  task automatic idle_ticks(input int n);
    rxd = 1'b1 ^ cfg_line_inv;
    for (int i = 0; i < n; i++) do_tick(1'b0);
  endtask

  task automatic build(input logic [8:0] d, input bit bad_par, input int bad_stop);
    int nb;
    logic p;
    nb = nbits_of(cfg_len);
    nlv = 0;
    lv[nlv] = 1'b0; nlv++;
    for (int i = 0; i < nb; i++) begin
      lv[nlv] = (cfg_msb_first ? d[nb-1-i] : d[i]) ^ cfg_data_inv;
      nlv++;
    end
    if (cfg_par_en) begin
      p = 1'b0;
      for (int i = 0; i < nb; i++) p = p ^ d[i];
      if (cfg_par_odd) p = ~p;
      lv[nlv] = p ^ cfg_data_inv ^ bad_par; nlv++;
    end
    for (int s = 0; s < (cfg_two_stop ? 2 : 1); s++) begin
      lv[nlv] = (s == bad_stop) ? 1'b0 : 1'b1; nlv++;
    end
  endtask

  // element j is sampled on tick 8 of its 16-tick window; rd_at selects one
  task automatic send(input int rd_at);
    for (int j = 0; j < nlv; j++) begin
      rxd = lv[j] ^ cfg_line_inv;
      for (int t = 0; t < 16; t++) do_tick(j == rd_at && t == 8);
    end
    idle_ticks(3);
  endtask

  task automatic read_buf();
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int k, nb, ib;
    logic [8:0] d, mask;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 reset full", rx_full, 0);
    check("R5 reset irq", rx_irq, 0);
    check("R8 reset sum", err_sum, 0);
    check("R13 reset rts disabled", rts_n, 0);

    // R1: disabled receiver ignores a frame
    build(9'h5A, 0, -1);
    ib = irq_cnt;
    send(-1);
    check("R1 no irq while disabled", irq_cnt - ib, 0);
    check("R1 no full while disabled", rx_full, 0);
    rx_en = 1'b1;
    idle_ticks(4);

    // sweep every configuration: R2 R3 R4 R9 R10 R11
    k = 0;
    for (int li = 0; li < 3; li++)
      for (int pm = 0; pm < 3; pm++)
        for (int st = 0; st < 2; st++)
          for (int mo = 0; mo < 2; mo++)
            for (int di = 0; di < 2; di++)
              for (int ln = 0; ln < 2; ln++) begin
                cfg_len = 2'(li); cfg_par_en = (pm != 0); cfg_par_odd = (pm == 2);
                cfg_two_stop = st[0]; cfg_msb_first = mo[0];
                cfg_data_inv = di[0]; cfg_line_inv = ln[0];
                idle_ticks(4);
                nb = nbits_of(cfg_len);
                mask = 9'((1 << nb) - 1);
                d = 9'((k * 73 + 29) & 32'(mask));
                build(d, 0, -1);
                ib = irq_cnt;
                send(-1);
                check("R2 R9 R10 R11 data", rx_data, d);
                check("R5 one irq", irq_cnt - ib, 1);
                check("R5 full", rx_full, 1);
                check("R3 R4 R8 no error", err_sum, 0);
                read_buf();
                check("R14 read clears", rx_full, 0);
                k++;
              end

    // R3 parity error, even and odd
    cfg_len = 2'd1; cfg_two_stop = 0; cfg_msb_first = 0; cfg_data_inv = 0;
    cfg_line_inv = 0; cfg_par_en = 1;
    for (int o = 0; o < 2; o++) begin
      cfg_par_odd = o[0];
      idle_ticks(4);
      build(9'h6B, 1, -1);
      ib = irq_cnt;
      send(-1);
      check("R3 parity flag", err_parity, 1);
      check("R8 sum on parity", err_sum, 1);
      check("R3 still stored", irq_cnt - ib, 1);
      read_buf();
    end

    // R4 framing error on each stop of a two-stop frame
    cfg_par_en = 0; cfg_two_stop = 1;
    for (int s = 0; s < 2; s++) begin
      idle_ticks(4);
      build(9'h33, 0, s);
      send(-1);
      check("R4 framing flag", err_framing, 1);
      check("R8 sum on framing", err_sum, 1);
      check("R4 data kept", rx_data, 9'h33);
      read_buf();
    end
    cfg_two_stop = 0;
    idle_ticks(4);
    build(9'h33, 0, -1);
    send(-1);
    check("R8 flags rewritten", err_sum, 0);

    // R12 short low pulse rejected
    read_buf();
    ib = irq_cnt;
    rxd = 1'b0;
    for (int t = 0; t < 4; t++) do_tick(1'b0);
    idle_ticks(200);
    check("R12 no irq on glitch", irq_cnt - ib, 0);
    check("R12 no full on glitch", rx_full, 0);
    build(9'hC4, 0, -1);
    send(-1);
    check("R12 next frame ok", rx_data, 9'hC4);

    // R6 R7 overrun with buffer unread (8N1: pre-last sample is element 8)
    build(9'h17, 0, -1);
    ib = irq_cnt;
    send(-1);
    check("R7 overrun flag", err_overrun, 1);
    check("R7 no irq on overrun", irq_cnt - ib, 0);
    check("R7 full kept", rx_full, 1);
    check("R8 sum on overrun", err_sum, 1);
    // R6 read coinciding with the overrun decision avoids overrun
    build(9'h1E5 & 9'hFF, 0, -1);
    ib = irq_cnt;
    send(8);
    check("R6 read at check avoids overrun", err_overrun, 0);
    check("R6 stored after race", rx_data, 9'h0E5);
    check("R6 irq after race", irq_cnt - ib, 1);
    // R14 read coinciding with store: store wins
    read_buf();
    build(9'h42, 0, -1);
    send(9);
    check("R14 store beats read", rx_full, 1);
    check("R14 data stored", rx_data, 9'h42);

    // R13 request to send
    cfg_rts_en = 1'b1;
    @(negedge clk);
    check("R13 busy when full", rts_n, 1);
    read_buf();
    check("R13 ready when empty", rts_n, 0);
    rx_en = 1'b0;
    @(negedge clk);
    check("R13 busy when disabled", rts_n, 1);
    check("R1 disable clears flags", err_sum, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule